// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register-side front end that launches one SD/MMC command at a time and records how it ended. Software first loads a 32-bit argument and then writes a 16-bit command word. Writing the command word starts the command. The block decodes that word and pulses a start strobe toward a command-line sequencer, together with the index, the argument and the expected response length. It then waits for the sequencer to report completion, the received response bits, and two check flags: CRC good and index match.

The block keeps two inhibit flags and a set of write-one-to-clear interrupt status bits, and it stores the response in four 32-bit words. While a flag is set, it refuses any command that would need that line. For a command with a busy-type response, the DAT inhibit flag stays set until the card releases DAT0. For a command that moves data, the flag stays set until the data path reports the transfer done. A programmable cycle limit bounds the wait for the sequencer. When the limit passes, the block raises a timeout instead of completion and tells the sequencer to abort.

Top module: `sd_cmd_issue`

## Requirements
- R1: When a command word is accepted, `seq_start` is high for exactly the next cycle. During that cycle `seq_index` equals word bits 13:8, `seq_rsp_len` equals word bits 1:0 (0 none, 1 long 136-bit, 2 short 48-bit, 3 short with busy), and `seq_arg` equals the last value written with `arg_we`.
- R2: `prs_state[0]` (CMD inhibit) is 1 from the cycle after an accepted command until completion or timeout is recorded.
- R3: A command write is ignored when CMD inhibit is set. It is also ignored when `prs_state[1]` (DAT inhibit) is set and the command uses DAT, meaning word bit 5 (data present) is set or bits 1:0 equal 3. An ignored write produces no `seq_start`, and the `seq_*` outputs keep their values.
- R4: DAT inhibit is set by an accepted command that uses DAT. For a busy type it clears once the command has ended and `dat_lvl[0]` is high. For a data-present command it clears on `dat_xfer_done`.
- R5: `prs_state[23:20]` mirror `dat_lvl[3:0]`. All other bits of `prs_state` above bit 1 are zero.
- R6: `seq_done` during a pending command sets `int_status[0]` (complete) and clears CMD inhibit at the same edge.
- R7: When a command completes, the response words are updated by response type. A long response stores the sequencer's 128 bits shifted right by 8, so the CRC byte is dropped and `resp3[31:24]` is zero. A short response, with or without busy, loads `resp0` with bits 31:0. Type 0 leaves all four words unchanged.
- R8: On completion, if word bit 3 (CRC check) was set and `seq_crc_ok` is low, `int_status[9]` is set.
- R9: On completion, if word bit 4 (index check) was set and `seq_idx_ok` is low, `int_status[11]` is set.
- R10: `int_status[15]` is 1 exactly when any of bits 8, 9 or 11 is 1.
- R11: `seq_done` is honoured in the `seq_start` cycle and in each of the following `tmo_limit` cycles. If it does not arrive in that window, `int_status[8]` (timeout) is set and complete is not, both inhibits clear, and `seq_abort` pulses for one cycle. A `seq_done` after that has no effect.
- R12: Writing `clr_wdata` with `clr_we` clears the status bits whose mask bit is 1 and leaves the others unchanged. When a bit is being set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_we | input | 1 | Command word write strobe (starts a command) |
| cmd_wdata | input | 16 | Command word |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | 16 | Write-one-to-clear mask for status |
| tmo_limit | input | TMO_W | Response wait limit in cycles |
| dat_lvl | input | 4 | Current DAT[3:0] line levels |
| dat_xfer_done | input | 1 | Data path reports end of transfer |
| seq_start | output | 1 | Start pulse to the command-line sequencer |
| seq_abort | output | 1 | Abort pulse after a timeout |
| seq_index | output | 6 | Command index for the sequencer |
| seq_arg | output | 32 | Command argument for the sequencer |
| seq_rsp_len | output | 2 | Expected response type |
| seq_done | input | 1 | Sequencer finished the command and response |
| seq_crc_ok | input | 1 | Response CRC was good |
| seq_idx_ok | input | 1 | Response index matched |
| seq_rsp | input | 128 | Received response bits |
| prs_state | output | 32 | Present state: inhibits and DAT levels |
| int_status | output | 16 | Interrupt status |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
Two pairs of events can fall in the same cycle. The first pair is completion and a software clear of the complete bit. The bench drives `seq_done` and a clear mask of bit 0 in the same cycle and expects the bit to stay set. The second pair is `seq_done` and the timeout limit. The bench raises `seq_done` exactly `tmo_limit` cycles after the start pulse and expects complete with no timeout. It then withholds `seq_done` for another command and expects timeout one cycle later, and it checks that a late `seq_done` after that changes nothing.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int ARG_W     = 32;
  localparam int CMD_W     = 16;
  localparam int STS_W     = 16;
  localparam int PRS_W     = 32;
  localparam int IDX_W     = 6;
  localparam int DAT_W     = 4;
  localparam int WORD_W    = 32;
  localparam int RSP_WORDS = 4;
  localparam int RSP_W     = WORD_W * RSP_WORDS;
  localparam int CRC_BYTE  = 8;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_TMO  = 8;
  localparam int ST_CRC  = 9;
  localparam int ST_IDX  = 11;
  localparam int ST_ERR  = 15;

  // present-state layout
  localparam int PS_CMD_INH = 0;
  localparam int PS_DAT_INH = 1;
  localparam int PS_DAT_LO  = 20;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_LONG       = 2'd1,
    RSP_SHORT      = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] index;
    logic             data_present;
    logic             idx_chk;
    logic             crc_chk;
    rsp_kind_e        kind;
  } cmd_fields_t;

  function automatic logic needs_dat(input cmd_fields_t f);
    return f.data_present | (f.kind == RSP_SHORT_BUSY);
  endfunction

  // long response image with the trailing CRC byte removed
  function automatic logic [RSP_W-1:0] drop_crc(input logic [RSP_W-1:0] raw);
    return {{CRC_BYTE{1'b0}}, raw[RSP_W-1:CRC_BYTE]};
  endfunction

endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
  import sd_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_we,
  input  logic             cmd_inh,
  input  logic             dat_inh,
  output cmd_fields_t      fields,
  output logic             accept
);

  logic unused_bits;
  assign unused_bits = ^{cmd_word[15:14], cmd_word[7:6], cmd_word[2]};

  always_comb begin
    fields.index        = cmd_word[13:8];
    fields.data_present = cmd_word[5];
    fields.idx_chk      = cmd_word[4];
    fields.crc_chk      = cmd_word[3];
    fields.kind         = rsp_kind_e'(cmd_word[1:0]);
  end

  assign accept = cmd_we & ~cmd_inh & ~(dat_inh & needs_dat(fields));

endmodule

// File: rtl/sd_cmd_timer.sv
module sd_cmd_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         disarm,
  input  logic [W-1:0] limit,
  output logic         running,
  output logic         hit
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (arm) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (disarm) begin
      running <= 1'b0;
    end else if (running && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = running & (cnt == limit);

endmodule

// File: rtl/sd_cmd_status.sv
module sd_cmd_status
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_mask,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] sts_o
);

  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_eff) | set_mask;
  end

  always_comb begin
    sts_o         = sts_q;
    sts_o[ST_ERR] = sts_q[ST_TMO] | sts_q[ST_CRC] | sts_q[ST_IDX];
  end

endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arg_we,
  input  logic [ARG_W-1:0]   arg_wdata,
  input  logic               cmd_we,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic               clr_we,
  input  logic [STS_W-1:0]   clr_wdata,
  input  logic [TMO_W-1:0]   tmo_limit,
  input  logic [DAT_W-1:0]   dat_lvl,
  input  logic               dat_xfer_done,
  output logic               seq_start,
  output logic               seq_abort,
  output logic [IDX_W-1:0]   seq_index,
  output logic [ARG_W-1:0]   seq_arg,
  output logic [1:0]         seq_rsp_len,
  input  logic               seq_done,
  input  logic               seq_crc_ok,
  input  logic               seq_idx_ok,
  input  logic [RSP_W-1:0]   seq_rsp,
  output logic [PRS_W-1:0]   prs_state,
  output logic [STS_W-1:0]   int_status,
  output logic [WORD_W-1:0]  resp0,
  output logic [WORD_W-1:0]  resp1,
  output logic [WORD_W-1:0]  resp2,
  output logic [WORD_W-1:0]  resp3
);

  localparam int DAT_HI = PS_DAT_LO + DAT_W - 1;

  // named internal events
  logic acc_evt, done_evt, tmo_evt;
  logic tmr_run, tmr_hit;

  cmd_fields_t       dec_fields;
  logic [ARG_W-1:0]  arg_q;
  logic              cmd_inh, busy_hold, data_hold, dat_inh;
  rsp_kind_e         kind_q;
  logic              crc_chk_q, idx_chk_q;
  logic [STS_W-1:0]  set_mask;
  logic [RSP_W-1:0]  long_img;
  logic [RSP_W-1:0]  resp_flat;

  assign dat_inh = busy_hold | data_hold;

  sd_cmd_decode u_dec (
    .cmd_word (cmd_wdata),
    .cmd_we   (cmd_we),
    .cmd_inh  (cmd_inh),
    .dat_inh  (dat_inh),
    .fields   (dec_fields),
    .accept   (acc_evt)
  );

  sd_cmd_timer #(.W(TMO_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (acc_evt),
    .disarm  (done_evt | tmo_evt),
    .limit   (tmo_limit),
    .running (tmr_run),
    .hit     (tmr_hit)
  );

  assign done_evt = tmr_run & seq_done;
  assign tmo_evt  = tmr_hit & ~seq_done;

  always_comb begin
    set_mask = '0;
    if (done_evt) begin
      set_mask[ST_DONE] = 1'b1;
      set_mask[ST_CRC]  = crc_chk_q & ~seq_crc_ok;
      set_mask[ST_IDX]  = idx_chk_q & ~seq_idx_ok;
    end
    if (tmo_evt) set_mask[ST_TMO] = 1'b1;
  end

  sd_cmd_status u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_we   (clr_we),
    .clr_mask (clr_wdata),
    .sts_o    (int_status)
  );

  // command launch and line inhibits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q       <= '0;
      cmd_inh     <= 1'b0;
      busy_hold   <= 1'b0;
      data_hold   <= 1'b0;
      kind_q      <= RSP_NONE;
      crc_chk_q   <= 1'b0;
      idx_chk_q   <= 1'b0;
      seq_start   <= 1'b0;
      seq_abort   <= 1'b0;
      seq_index   <= '0;
      seq_arg     <= '0;
      seq_rsp_len <= '0;
    end else begin
      seq_start <= acc_evt;
      seq_abort <= tmo_evt;
      if (arg_we) arg_q <= arg_wdata;

      if (acc_evt) begin
        cmd_inh     <= 1'b1;
        kind_q      <= dec_fields.kind;
        crc_chk_q   <= dec_fields.crc_chk;
        idx_chk_q   <= dec_fields.idx_chk;
        seq_index   <= dec_fields.index;
        seq_arg     <= arg_q;
        seq_rsp_len <= dec_fields.kind;
      end else if (done_evt || tmo_evt) begin
        cmd_inh <= 1'b0;
      end

      if (tmo_evt) begin
        busy_hold <= 1'b0;
        data_hold <= 1'b0;
      end else begin
        if (busy_hold && !cmd_inh && dat_lvl[0]) busy_hold <= 1'b0;
        if (data_hold && dat_xfer_done)          data_hold <= 1'b0;
        if (acc_evt && dec_fields.kind == RSP_SHORT_BUSY) busy_hold <= 1'b1;
        if (acc_evt && dec_fields.data_present)           data_hold <= 1'b1;
      end
    end
  end

  // response words
  assign long_img = drop_crc(seq_rsp);

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_rsp
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (done_evt) begin
        if (kind_q == RSP_LONG)
          word_q <= long_img[w*WORD_W +: WORD_W];
        else if (w == 0 && (kind_q == RSP_SHORT || kind_q == RSP_SHORT_BUSY))
          word_q <= seq_rsp[WORD_W-1:0];
      end
    end
    assign resp_flat[w*WORD_W +: WORD_W] = word_q;
  end

  assign resp0 = resp_flat[0*WORD_W +: WORD_W];
  assign resp1 = resp_flat[1*WORD_W +: WORD_W];
  assign resp2 = resp_flat[2*WORD_W +: WORD_W];
  assign resp3 = resp_flat[3*WORD_W +: WORD_W];

  always_comb begin
    prs_state                 = '0;
    prs_state[PS_CMD_INH]     = cmd_inh;
    prs_state[PS_DAT_INH]     = dat_inh;
    prs_state[DAT_HI:PS_DAT_LO] = dat_lvl;
  end

endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_evt,
  input logic        done_evt,
  input logic        tmo_evt,
  input logic        cmd_we,
  input logic        seq_start,
  input logic        seq_abort,
  input logic [31:0] prs_state,
  input logic [15:0] int_status
);

  a_r1_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> seq_start);

  a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  a_r2_inhibit_raised: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> prs_state[0]);

  a_r3_reject_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && prs_state[0]) |=> !seq_start);

  a_r6_done_sets_complete: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (int_status[0] && !prs_state[0]));

  a_r11_timeout_effects: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (int_status[8] && seq_abort && !prs_state[0] && !prs_state[1]));

  a_r10_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_status[9]) || $rose(int_status[11]) || $rose(int_status[8])) |-> int_status[15]);

endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_evt    (acc_evt),
  .done_evt   (done_evt),
  .tmo_evt    (tmo_evt),
  .cmd_we     (cmd_we),
  .seq_start  (seq_start),
  .seq_abort  (seq_abort),
  .prs_state  (prs_state),
  .int_status (int_status)
);

// File: tb/sd_cmd_issue_tb.sv
module sd_cmd_issue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arg_we = 0, cmd_we = 0, clr_we = 0;
  logic [31:0]  arg_wdata = '0;
  logic [15:0]  cmd_wdata = '0, clr_wdata = '0;
  logic [15:0]  tmo_limit = LIMIT[15:0];
  logic [3:0]   dat_lvl = 4'hF;
  logic         dat_xfer_done = 0;
  logic         seq_start, seq_abort;
  logic [5:0]   seq_index;
  logic [31:0]  seq_arg;
  logic [1:0]   seq_rsp_len;
  logic         seq_done = 0, seq_crc_ok = 1, seq_idx_ok = 1;
  logic [127:0] seq_rsp = '0;
  logic [31:0]  prs_state;
  logic [15:0]  int_status;
  logic [31:0]  resp0, resp1, resp2, resp3;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_issue u_dut (
    .clk(clk), .rst_n(rst_n),
    .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .tmo_limit(tmo_limit), .dat_lvl(dat_lvl), .dat_xfer_done(dat_xfer_done),
    .seq_start(seq_start), .seq_abort(seq_abort), .seq_index(seq_index),
    .seq_arg(seq_arg), .seq_rsp_len(seq_rsp_len),
    .seq_done(seq_done), .seq_crc_ok(seq_crc_ok), .seq_idx_ok(seq_idx_ok),
    .seq_rsp(seq_rsp),
    .prs_state(prs_state), .int_status(int_status),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
  );

  typedef struct {
    logic [15:0]  sts;
    logic [127:0] rsp;
    string        tag;
  } exp_item_t;

  exp_item_t    exp_q[$];
  int           checks = 0;
  int           errors = 0;
  logic [15:0]  cur_cw;
  logic [127:0] mdl_rsp = '0;
  logic         inh_d = 1'b0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: on every end of a command compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n && inh_d && !prs_state[0]) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected completion", {112'd0, int_status}, 128'd0);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        chk({"R6/R8/R9/R10/R11 status ", it.tag}, {112'd0, int_status}, {112'd0, it.sts});
        chk({"R7 response ", it.tag}, {resp3, resp2, resp1, resp0}, it.rsp);
      end
    end
    inh_d = prs_state[0];
  end

  task automatic start_cmd(input logic [15:0] cw, input logic [31:0] a);
    arg_we = 1; arg_wdata = a;
    @(negedge clk);
    arg_we = 0; cmd_we = 1; cmd_wdata = cw; cur_cw = cw;
    @(negedge clk);
    cmd_we = 0;
    chk("R1 start pulse", {127'd0, seq_start}, 128'd1);
    chk("R1 index", {122'd0, seq_index}, {122'd0, cw[13:8]});
    chk("R1 argument", {96'd0, seq_arg}, {96'd0, a});
    chk("R1 response length", {126'd0, seq_rsp_len}, {126'd0, cw[1:0]});
    chk("R2 cmd inhibit set", {127'd0, prs_state[0]}, 128'd1);
  endtask

  task automatic finish_cmd(input int lat, input bit crc_ok, input bit idx_ok,
                            input logic [127:0] raw, input bit keep,
                            input bit clr_same, input string tag);
    exp_item_t   it;
    logic [15:0] s;
    repeat (lat) @(negedge clk);
    case (cur_cw[1:0])
      2'b01:        mdl_rsp = raw >> 8;
      2'b10, 2'b11: mdl_rsp[31:0] = raw[31:0];
      default:      ;
    endcase
    s = 16'h0001;
    if (cur_cw[3] && !crc_ok) s = s | 16'h0200;
    if (cur_cw[4] && !idx_ok) s = s | 16'h0800;
    if ((s & 16'h0A00) != 0)  s = s | 16'h8000;
    it.sts = s; it.rsp = mdl_rsp; it.tag = tag;
    exp_q.push_back(it);
    seq_done = 1; seq_crc_ok = crc_ok; seq_idx_ok = idx_ok; seq_rsp = raw;
    if (clr_same) begin clr_we = 1; clr_wdata = 16'h0001; end
    @(negedge clk);
    seq_done = 0; clr_we = 0; seq_crc_ok = 1; seq_idx_ok = 1;
    if (!keep) begin
      @(negedge clk);
      clr_we = 1; clr_wdata = 16'hFFFF;
      @(negedge clk);
      clr_we = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R5 reset present state", {96'd0, prs_state}, {96'd0, 32'h00F0_0000});
    chk("R12 reset status", {112'd0, int_status}, 128'd0);
    chk("R7 reset response", {resp3, resp2, resp1, resp0}, 128'd0);
    chk("R1 reset no start", {127'd0, seq_start}, 128'd0);

    // R1 R6 R7 short response with both checks passing
    start_cmd(16'h1D1A, 32'hCAFE_0001);
    finish_cmd(3, 1, 1, 128'h1111_2222_3333_4444_5555_6666_0000_0900, 0, 0, "short ok");

    // R7 long response, CRC byte removed
    start_cmd(16'h0209, 32'h0);
    finish_cmd(5, 1, 1, 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4, 0, 0, "long");

    // R7 no response leaves words unchanged; latency 0
    start_cmd(16'h0000, 32'h0);
    finish_cmd(0, 0, 0, 128'hFFFF, 0, 0, "none");

    // R8 CRC error with check on; R9 index error with check on
    start_cmd(16'h0D0A, 32'h5);
    finish_cmd(2, 0, 1, 128'h77, 0, 0, "crc err");
    start_cmd(16'h0D12, 32'h6);
    finish_cmd(2, 1, 0, 128'h78, 0, 0, "idx err");
    // R8 R9 bad flags ignored when checks are off
    start_cmd(16'h0D02, 32'h7);
    finish_cmd(2, 0, 0, 128'h79, 0, 0, "checks off");

    // R3 write during a pending command is ignored
    start_cmd(16'h0702, 32'h10);
    cmd_we = 1; cmd_wdata = 16'h2A02;
    @(negedge clk);
    cmd_we = 0;
    @(negedge clk);
    chk("R3 no start while CMD inhibit", {127'd0, seq_start}, 128'd0);
    chk("R3 index unchanged", {122'd0, seq_index}, 128'd7);
    finish_cmd(1, 1, 1, 128'h80, 0, 0, "after reject");

    // R4 R5 busy response holds DAT inhibit while DAT0 low
    dat_lvl = 4'b1110;
    start_cmd(16'h0C03, 32'h20);
    chk("R4 DAT inhibit set on busy", {127'd0, prs_state[1]}, 128'd1);
    finish_cmd(2, 1, 1, 128'h900, 0, 0, "busy");
    chk("R4 DAT inhibit held, DAT0 low", {127'd0, prs_state[1]}, 128'd1);
    chk("R5 DAT levels", {124'd0, prs_state[23:20]}, {124'd0, 4'b1110});
    cmd_we = 1; cmd_wdata = 16'h0C03;
    @(negedge clk);
    cmd_we = 0;
    @(negedge clk);
    chk("R3 busy cmd rejected under DAT inhibit", {127'd0, seq_start}, 128'd0);
    start_cmd(16'h0D02, 32'h21);
    finish_cmd(1, 1, 1, 128'h901, 0, 0, "no-DAT under DAT inhibit");
    dat_lvl = 4'b1111;
    repeat (2) @(negedge clk);
    chk("R4 DAT inhibit clears on DAT0 high", {127'd0, prs_state[1]}, 128'd0);
    chk("R5 DAT levels", {124'd0, prs_state[23:20]}, 128'hF);

    // R4 data-present command
    start_cmd(16'h1122, 32'h30);
    chk("R4 DAT inhibit set on data", {127'd0, prs_state[1]}, 128'd1);
    finish_cmd(1, 1, 1, 128'h902, 0, 0, "data");
    chk("R4 DAT inhibit held until transfer end", {127'd0, prs_state[1]}, 128'd1);
    dat_xfer_done = 1;
    @(negedge clk);
    dat_xfer_done = 0;
    chk("R4 DAT inhibit cleared by transfer end", {127'd0, prs_state[1]}, 128'd0);

    // R11 boundary: done exactly at the limit is honoured
    start_cmd(16'h0302, 32'h40);
    finish_cmd(LIMIT, 1, 1, 128'h903, 0, 0, "done at limit");

    // R11 timeout
    start_cmd(16'h0402, 32'h41);
    repeat (LIMIT) @(negedge clk);
    chk("R11 no timeout before window ends", {127'd0, int_status[8]}, 128'd0);
    chk("R2 inhibit still set at window end", {127'd0, prs_state[0]}, 128'd1);
    begin
      exp_item_t it;
      it.sts = 16'h8100; it.rsp = mdl_rsp; it.tag = "timeout";
      exp_q.push_back(it);
    end
    @(negedge clk);
    chk("R11 abort pulse", {127'd0, seq_abort}, 128'd1);
    seq_done = 1; seq_rsp = 128'hDEAD;
    @(negedge clk);
    seq_done = 0;
    chk("R11 late done ignored", {112'd0, int_status}, 128'h8100);
    chk("R11 abort single pulse", {127'd0, seq_abort}, 128'd0);
    clr_we = 1; clr_wdata = 16'h0100;
    @(negedge clk);
    clr_we = 0;
    chk("R10 summary drops with timeout cleared", {112'd0, int_status}, 128'd0);

    // R12 selective clear and set-wins
    start_cmd(16'h050A, 32'h50);
    finish_cmd(1, 0, 1, 128'h904, 1, 0, "keep");
    clr_we = 1; clr_wdata = 16'h0200;
    @(negedge clk);
    clr_we = 0;
    chk("R12 clear CRC bit only", {112'd0, int_status}, 128'h0001);
    clr_we = 1; clr_wdata = 16'h0001;
    @(negedge clk);
    clr_we = 0;
    chk("R12 clear complete", {112'd0, int_status}, 128'd0);
    start_cmd(16'h0602, 32'h51);
    finish_cmd(1, 1, 1, 128'h905, 1, 1, "set wins over clear");
    chk("R12 set wins", {112'd0, int_status}, 128'h0001);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 128'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule